// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for one of three access kinds: read, write or instruction fetch. Two upper windows of the address space skip translation. One of them loses its top three address bits and the other passes through unchanged. Both windows are open to privileged code. User code may reach only a small window in the upper region. When translation is switched off, every other address has its top three bits cleared. When translation is on, the address is looked up in a fully associative table of page entries. Each entry has one of four page sizes, an address-space tag and a share flag, two protection bits and a dirty bit. Every lookup that consults the table also advances a replacement index. That index wraps at a bound that software chooses.

A request is presented for one cycle. The block returns a registered result on the next cycle: a fault flag, a 12-bit exception code and a physical address. Software fills the table through a write port. The write port always targets the slot named by the replacement index, which is visible on `repl_idx`.

Top module: `vaddr_xlate_unit`

## Requirements
- R1: For a privileged access, an address from 0x80000000 to 0xBFFFFFFF returns the address with bits 31:29 cleared. An address at or above 0xE0000000 returns unchanged. Neither raises a fault or consults the table.
- R2: A user-mode access (`priv_mode`=0) to either untranslated window faults. The exception is 0xE0000000 to 0xE3FFFFFF, which is translated as in R1. The fault code is 0x100 for a write (`req_kind`=1) and 0x0E0 for a read (0) or fetch (2). The returned address is 0.
- R3: With `xlat_en`=0, any address outside the R1 windows returns with bits 31:29 cleared, with no fault and no table access.
- R4: Size code 0, 1, 2 and 3 gives a page of 1 KB, 4 KB, 64 KB and 1 MB. An entry covers the addresses whose bits above the page offset equal those of {VPN,10'b0}. On a clean hit the physical address is ({PPN,10'b0} with the offset bits cleared) ORed with the request's page offset.
- R5: Only valid entries compare. The tag is compared with `cur_asid` only when the entry's share flag is 0 and tags are in force. Tags are in force when `sv_mode`=0 or the access is from user mode.
- R6: Two or more matching entries give fault code 0x140.
- R7: No matching entry gives code 0x060 for a write and 0x040 for a read or fetch.
- R8: In user mode, a hit with protection bit 1 clear gives 0x0C0 for a write and 0x0A0 otherwise. A write that hits an entry with protection bit 0 clear gives 0x0C0.
- R9: A permitted write that hits an entry whose dirty bit is 0 gives code 0x080. Every fault returns physical address 0, and a result without a fault carries code 0.
- R10: The replacement index resets to 0 and steps by one on each request that consults the table. It goes to 0 instead when the next value would exceed a nonzero `repl_bound`, or would exceed the last entry index. Other requests leave it unchanged.
- R11: A request in cycle n gives `rsp_valid`=1 and its result in cycle n+1. `rsp_valid` is 0 after reset and in cycles that follow no request. All entries are invalid after reset.
- R12: A write-port pulse loads VPN, tag, valid, PPN, size, share, protection and dirty into the slot at the current replacement index. The entry is seen by lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| priv_mode | input | 1 | 1 for privileged access |
| xlat_en | input | 1 | Translation enable |
| sv_mode | input | 1 | Ignore tags for privileged accesses |
| repl_bound | input | IDX_W | Wrap bound of the replacement index (0 = full table) |
| cur_asid | input | 8 | Current address-space tag |
| wr_en | input | 1 | Entry write strobe |
| wr_vpn | input | 22 | Virtual page number |
| wr_asid | input | 8 | Entry tag |
| wr_valid | input | 1 | Entry valid |
| wr_ppn | input | 19 | Physical page number |
| wr_size | input | 2 | Page-size code |
| wr_share | input | 1 | Share flag |
| wr_prot | input | 2 | Protection bits |
| wr_dirty | input | 1 | Dirty bit |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Fault flag |
| rsp_code | output | 12 | Exception code, 0 when no fault |
| rsp_paddr | output | 32 | Physical address |
| repl_idx | output | IDX_W | Replacement index |

## Verification
The fault flag, code, address and valid strobe all come from one register stage, so each is due on the first rising edge after the request. The replacement index moves on that same edge. A table write is seen by a lookup issued in any later cycle. The bench drives every request on a falling edge and samples all results on the next falling edge. At that point it compares them with an arithmetic model and a shadow copy of the replacement index, both stepped in the same order as the hardware.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int VA_W       = 32;
    localparam int OFS_BITS   = 10;
    localparam int VPN_W      = VA_W - OFS_BITS;
    localparam int PA_TOP_W   = 29;
    localparam int PPN_W      = PA_TOP_W - OFS_BITS;
    localparam int ASID_W     = 8;
    localparam int CODE_W     = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_t;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_t;

    localparam logic [CODE_W-1:0] EXC_NONE     = 12'h000;
    localparam logic [CODE_W-1:0] EXC_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] EXC_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] EXC_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] EXC_PROT_RD  = 12'h0A0;
    localparam logic [CODE_W-1:0] EXC_PROT_WR  = 12'h0C0;
    localparam logic [CODE_W-1:0] EXC_ADDR_RD  = 12'h0E0;
    localparam logic [CODE_W-1:0] EXC_ADDR_WR  = 12'h100;
    localparam logic [CODE_W-1:0] EXC_MULTI    = 12'h140;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        pg_size_t         size;
        logic [1:0]       prot;
        logic             dirty;
    } pg_attr_t;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              share;
        pg_attr_t          attr;
    } pg_entry_t;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [VA_W-1:0]   paddr;
    } xlat_rsp_t;

    function automatic logic [VA_W-1:0] offset_mask(pg_size_t sz);
        case (sz)
            PG_1K:   offset_mask = 32'h0000_03FF;
            PG_4K:   offset_mask = 32'h0000_0FFF;
            PG_64K:  offset_mask = 32'h0000_FFFF;
            default: offset_mask = 32'h000F_FFFF;
        endcase
    endfunction

    function automatic xlat_rsp_t fault_rsp(logic [CODE_W-1:0] c);
        fault_rsp = '{fault: 1'b1, code: c, paddr: '0};
    endfunction

    function automatic xlat_rsp_t ok_rsp(logic [VA_W-1:0] pa);
        ok_rsp = '{fault: 1'b0, code: EXC_NONE, paddr: pa};
    endfunction

endpackage

// File: rtl/vat_region.sv
module vat_region
    import vat_pkg::*;
(
    input  logic [VA_W-1:0] addr,
    input  logic            priv,
    output logic            flat,
    output logic            user_err,
    output logic [VA_W-1:0] flat_pa
);
    logic mid_win;
    logic top_win;
    logic user_win;

    assign mid_win  = (addr[31:30] == 2'b10);
    assign top_win  = (addr[31:29] == 3'b111);
    assign user_win = (addr[31:26] == 6'b111000);

    assign flat     = mid_win || top_win;
    assign user_err = !priv && (mid_win || (top_win && !user_win));
    assign flat_pa  = mid_win ? {3'b000, addr[28:0]} : addr;
endmodule

// File: rtl/vat_entry_array.sv
module vat_entry_array
    import vat_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  pg_entry_t         wr_entry,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              tag_on,
    output logic              hit_any,
    output logic              hit_multi,
    output pg_attr_t          hit_attr
);
    logic [DEPTH-1:0] hit_vec;
    pg_attr_t         attr_all [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        pg_entry_t       ent_q;
        logic [VA_W-1:0] msk;
        logic            tag_ok;
        logic            page_ok;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q.valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q <= wr_entry;
            end
        end

        assign msk     = offset_mask(ent_q.attr.size);
        assign tag_ok  = ent_q.share || !tag_on || (ent_q.asid == lk_asid);
        assign page_ok = (({ent_q.vpn, 10'b0} & ~msk) == (lk_addr & ~msk));
        assign hit_vec[g]  = ent_q.valid && tag_ok && page_ok;
        assign attr_all[g] = ent_q.attr;
    end

    always_comb begin
        hit_attr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_attr = pg_attr_t'(hit_attr | attr_all[i]);
            end
        end
    end

    assign hit_any   = |hit_vec;
    assign hit_multi = ((hit_vec & (hit_vec - 1'b1)) != '0);
endmodule

// File: rtl/vat_repl_ctr.sv
module vat_repl_ctr #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] count
);
    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(DEPTH - 1);

    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W:0]   nxt;
    logic             wrap;

    assign nxt  = {1'b0, cnt_q} + 1'b1;
    assign wrap = ((bound != '0) && (nxt > {1'b0, bound})) || (nxt > LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : nxt[IDX_W-1:0];
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/vaddr_xlate_unit.sv
module vaddr_xlate_unit
    import vat_pkg::*;
#(
    parameter  int NUM_ENTRIES = 64,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic [1:0]        req_kind,
    input  logic              priv_mode,
    input  logic              xlat_en,
    input  logic              sv_mode,
    input  logic [IDX_W-1:0]  repl_bound,
    input  logic [7:0]        cur_asid,
    input  logic              wr_en,
    input  logic [21:0]       wr_vpn,
    input  logic [7:0]        wr_asid,
    input  logic              wr_valid,
    input  logic [18:0]       wr_ppn,
    input  logic [1:0]        wr_size,
    input  logic              wr_share,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic [IDX_W-1:0]  repl_idx
);
    logic            is_write;
    logic            flat;
    logic            user_err;
    logic [VA_W-1:0] flat_pa;
    logic            tag_on;
    logic            tlb_step;
    logic            hit_any;
    logic            hit_multi;
    pg_attr_t        hit_attr;
    pg_entry_t       wr_entry;
    logic [VA_W-1:0] pg_msk;
    logic [VA_W-1:0] mapped_pa;
    xlat_rsp_t       rsp_d;
    xlat_rsp_t       rsp_q;
    logic            vld_q;

    assign is_write = (req_kind == ACC_WRITE);
    assign tag_on   = !sv_mode || !priv_mode;
    assign tlb_step = req_valid && xlat_en && !flat;

    always_comb begin
        wr_entry.valid      = wr_valid;
        wr_entry.vpn        = wr_vpn;
        wr_entry.asid       = wr_asid;
        wr_entry.share      = wr_share;
        wr_entry.attr.ppn   = wr_ppn;
        wr_entry.attr.size  = pg_size_t'(wr_size);
        wr_entry.attr.prot  = wr_prot;
        wr_entry.attr.dirty = wr_dirty;
    end

    vat_region u_region (
        .addr     (req_addr),
        .priv     (priv_mode),
        .flat     (flat),
        .user_err (user_err),
        .flat_pa  (flat_pa)
    );

    vat_entry_array #(
        .DEPTH (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (repl_idx),
        .wr_entry  (wr_entry),
        .lk_addr   (req_addr),
        .lk_asid   (cur_asid),
        .tag_on    (tag_on),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_attr  (hit_attr)
    );

    vat_repl_ctr #(
        .DEPTH (NUM_ENTRIES),
        .IDX_W (IDX_W)
    ) u_repl (
        .clk   (clk),
        .rst   (rst),
        .step  (tlb_step),
        .bound (repl_bound),
        .count (repl_idx)
    );

    assign pg_msk    = offset_mask(hit_attr.size);
    assign mapped_pa = ({3'b000, hit_attr.ppn, 10'b0} & ~pg_msk) | (req_addr & pg_msk);

    always_comb begin
        if (flat) begin
            if (user_err) begin
                rsp_d = fault_rsp(is_write ? EXC_ADDR_WR : EXC_ADDR_RD);
            end else begin
                rsp_d = ok_rsp(flat_pa);
            end
        end else if (!xlat_en) begin
            rsp_d = ok_rsp({3'b000, req_addr[28:0]});
        end else if (hit_multi) begin
            rsp_d = fault_rsp(EXC_MULTI);
        end else if (!hit_any) begin
            rsp_d = fault_rsp(is_write ? EXC_MISS_WR : EXC_MISS_RD);
        end else if (!priv_mode && !hit_attr.prot[1]) begin
            rsp_d = fault_rsp(is_write ? EXC_PROT_WR : EXC_PROT_RD);
        end else if (is_write && !hit_attr.prot[0]) begin
            rsp_d = fault_rsp(EXC_PROT_WR);
        end else if (is_write && !hit_attr.dirty) begin
            rsp_d = fault_rsp(EXC_FIRST_WR);
        end else begin
            rsp_d = ok_rsp(mapped_pa);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                rsp_q <= rsp_d;
            end
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_fault = rsp_q.fault;
    assign rsp_code  = rsp_q.code;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/vat_checker.sv
module vat_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic [1:0]       req_kind,
    input logic             priv_mode,
    input logic             xlat_en,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [11:0]      rsp_code,
    input logic [31:0]      rsp_paddr,
    input logic [IDX_W-1:0] repl_idx
);
    logic mid_req;
    logic table_req;

    assign mid_req   = req_valid && (req_addr[31:30] == 2'b10);
    assign table_req = req_valid && xlat_en && (req_addr[31:30] != 2'b10)
                       && (req_addr[31:29] != 3'b111);

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_mid_window_R1: assert property (@(posedge clk) disable iff (rst)
        (mid_req && priv_mode) |=>
            (!rsp_fault && rsp_paddr == {3'b000, $past(req_addr[28:0])}));

    assert_user_window_R2: assert property (@(posedge clk) disable iff (rst)
        (mid_req && !priv_mode) |=>
            (rsp_fault && rsp_code == (($past(req_kind) == 2'd1) ? 12'h100 : 12'h0E0)));

    assert_xlat_off_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlat_en && !req_addr[31]) |=>
            (!rsp_fault && rsp_paddr == {3'b000, $past(req_addr[28:0])}));

    assert_repl_steps_R10: assert property (@(posedge clk) disable iff (rst)
        table_req |=> (repl_idx != $past(repl_idx)));

    assert_repl_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !table_req |=> $stable(repl_idx));

    assert_fault_has_code_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_code != 12'h000)));
endmodule

bind vaddr_xlate_unit vat_checker #(.IDX_W(IDX_W)) u_vat_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .priv_mode (priv_mode),
    .xlat_en   (xlat_en),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_code  (rsp_code),
    .rsp_paddr (rsp_paddr),
    .repl_idx  (repl_idx)
);

// File: tb/test_vaddr_xlate_unit.sv
`timescale 1ns/1ps
module test_vaddr_xlate_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_kind;
    logic        priv_mode;
    logic        xlat_en;
    logic        sv_mode;
    logic [5:0]  repl_bound;
    logic [7:0]  cur_asid;
    logic        wr_en;
    logic [21:0] wr_vpn;
    logic [7:0]  wr_asid;
    logic        wr_valid;
    logic [18:0] wr_ppn;
    logic [1:0]  wr_size;
    logic        wr_share;
    logic [1:0]  wr_prot;
    logic        wr_dirty;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [11:0] rsp_code;
    logic [31:0] rsp_paddr;
    logic [5:0]  repl_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int m_urc  = 0;

    bit          m_v   [64];
    logic [21:0] m_vpn [64];
    logic [7:0]  m_asid[64];
    logic [18:0] m_ppn [64];
    int          m_sz  [64];
    bit          m_sh  [64];
    logic [1:0]  m_pr  [64];
    bit          m_d   [64];

    always #5 clk = ~clk;

    vaddr_xlate_unit i_vaddr_xlate_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .priv_mode(priv_mode), .xlat_en(xlat_en),
        .sv_mode(sv_mode), .repl_bound(repl_bound), .cur_asid(cur_asid),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_valid(wr_valid),
        .wr_ppn(wr_ppn), .wr_size(wr_size), .wr_share(wr_share),
        .wr_prot(wr_prot), .wr_dirty(wr_dirty), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
        .repl_idx(repl_idx)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Arithmetic reference model built from the requirement text.
    task automatic model(input logic [31:0] a, input int kind, input bit pr,
                         output logic [44:0] exp, output string tag, output bit tlb);
        bit      wr;
        longint  ua;
        longint  sz;
        longint  start;
        longint  pa;
        int      nh;
        int      hi;
        bit      tag_ok;
        wr  = (kind == 1);
        ua  = longint'(a);
        tlb = 1'b0;
        nh  = 0;
        hi  = 0;
        if ((ua >= 64'h8000_0000 && ua < 64'hC000_0000) || ua >= 64'hE000_0000) begin
            if (!pr && !(ua >= 64'hE000_0000 && ua < 64'hE400_0000)) begin
                exp = {1'b1, (wr ? 12'h100 : 12'h0E0), 32'h0};
                tag = "R2";
            end else if (ua < 64'hC000_0000) begin
                pa  = ua % 64'h2000_0000;
                exp = {1'b0, 12'h000, pa[31:0]};
                tag = "R1";
            end else begin
                exp = {1'b0, 12'h000, a};
                tag = "R1";
            end
        end else if (!xlat_en) begin
            pa  = ua % 64'h2000_0000;
            exp = {1'b0, 12'h000, pa[31:0]};
            tag = "R3";
        end else begin
            tlb = 1'b1;
            for (int i = 0; i < 64; i++) begin
                if (m_v[i]) begin
                    tag_ok = m_sh[i] || (sv_mode && pr) || (m_asid[i] == cur_asid);
                    sz = (m_sz[i] == 0) ? 1024 : (m_sz[i] == 1) ? 4096 :
                         (m_sz[i] == 2) ? 65536 : 1048576;
                    start = (longint'(m_vpn[i]) * 1024) / sz * sz;
                    if (tag_ok && ua >= start && ua < start + sz) begin
                        nh++;
                        hi = i;
                    end
                end
            end
            if (nh > 1) begin
                exp = {1'b1, 12'h140, 32'h0}; tag = "R6";
            end else if (nh == 0) begin
                exp = {1'b1, (wr ? 12'h060 : 12'h040), 32'h0}; tag = "R7";
            end else if (!pr && !m_pr[hi][1]) begin
                exp = {1'b1, (wr ? 12'h0C0 : 12'h0A0), 32'h0}; tag = "R8";
            end else if (wr && !m_pr[hi][0]) begin
                exp = {1'b1, 12'h0C0, 32'h0}; tag = "R8";
            end else if (wr && !m_d[hi]) begin
                exp = {1'b1, 12'h080, 32'h0}; tag = "R9";
            end else begin
                sz = (m_sz[hi] == 0) ? 1024 : (m_sz[hi] == 1) ? 4096 :
                     (m_sz[hi] == 2) ? 65536 : 1048576;
                pa = (longint'(m_ppn[hi]) * 1024) / sz * sz + (ua % sz);
                exp = {1'b0, 12'h000, pa[31:0]};
                tag = "R4";
            end
        end
    endtask

    task automatic look(input logic [31:0] a, input int kind, input bit pr, input string ctx);
        logic [44:0] exp;
        string       tag;
        bit          tlb;
        int          nx;
        @(negedge clk);
        req_addr  = a;
        req_kind  = 2'(kind);
        priv_mode = pr;
        req_valid = 1'b1;
        model(a, kind, pr, exp, tag, tlb);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R11", "result strobe", 64'(rsp_valid), 64'd1);
        chk({rsp_fault, rsp_code, rsp_paddr} === exp, tag,
            $sformatf("%s addr=%h kind=%0d priv=%0d", ctx, a, kind, pr),
            64'({rsp_fault, rsp_code, rsp_paddr}), 64'(exp));
        if (tlb) begin
            nx = m_urc + 1;
            if ((repl_bound != 6'd0 && nx > int'(repl_bound)) || nx > 63) nx = 0;
            m_urc = nx;
        end
        chk(repl_idx === 6'(m_urc), "R10", "replacement index",
            64'(repl_idx), 64'(m_urc));
    endtask

    task automatic put(input logic [31:0] va, input logic [31:0] pa, input int sz,
                       input bit v, input bit sh, input logic [1:0] prt,
                       input bit d, input logic [7:0] as);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = va[31:10]; wr_ppn = pa[28:10]; wr_size = 2'(sz);
        wr_valid = v; wr_share = sh; wr_prot = prt; wr_dirty = d; wr_asid = as;
        m_v[m_urc] = v; m_vpn[m_urc] = va[31:10]; m_ppn[m_urc] = pa[28:10];
        m_sz[m_urc] = sz; m_sh[m_urc] = sh; m_pr[m_urc] = prt; m_d[m_urc] = d;
        m_asid[m_urc] = as;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11", "idle strobe", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    logic [31:0] pts [12];

    initial begin
        rst = 1'b1; req_valid = 0; req_addr = 0; req_kind = 0; priv_mode = 0;
        xlat_en = 0; sv_mode = 0; repl_bound = 0; cur_asid = 0; wr_en = 0;
        wr_vpn = 0; wr_asid = 0; wr_valid = 0; wr_ppn = 0; wr_size = 0;
        wr_share = 0; wr_prot = 0; wr_dirty = 0;
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R11", "reset strobe", 64'(rsp_valid), 64'd0);
        chk(repl_idx === 6'd0, "R10", "reset index", 64'(repl_idx), 64'd0);

        // Region rules with translation off (R1, R2, R3).
        for (int nib = 0; nib < 16; nib++)
            for (int k = 0; k < 3; k++)
                for (int p = 0; p < 2; p++)
                    look({4'(nib), 28'h5A5_A5A4}, k, p[0], "R1/R2/R3 region sweep");
        for (int k = 0; k < 2; k++)
            for (int p = 0; p < 2; p++) begin
                look(32'hE3FF_FFFC, k, p[0], "R2 window top");
                look(32'hE400_0000, k, p[0], "R2 past window");
                look(32'hBFFF_FFFC, k, p[0], "R1 window end");
                look(32'hC000_0000, k, p[0], "R3 mapped start");
                look(32'h7FFF_FFFC, k, p[0], "R3 low end");
            end
        idle_chk();

        // Empty table with translation on (R7, R11).
        xlat_en = 1'b1; cur_asid = 8'd5;
        for (int nib = 0; nib < 16; nib++)
            for (int k = 0; k < 3; k++)
                look({4'(nib), 28'h012_3450}, k, 1'b1, "R7 empty table");

        // Fill entries at successive replacement slots (R12).
        put(32'h0040_0000, 32'h0123_4000, 1, 1, 0, 2'b11, 1, 8'd5);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");
        put(32'h1000_0000, 32'h002A_F000, 0, 1, 1, 2'b10, 1, 8'h33);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");
        put(32'h2000_0000, 32'h0555_0000, 2, 1, 0, 2'b01, 0, 8'd5);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");
        put(32'hC010_0C00, 32'h0AB0_1400, 3, 1, 0, 2'b11, 1, 8'd7);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");
        put(32'h0040_0000, 32'h1FF0_0000, 3, 1, 1, 2'b11, 1, 8'd0);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");
        put(32'h3000_0000, 32'h0000_0000, 1, 0, 1, 2'b11, 1, 8'd0);
        look(32'h3000_0000, 0, 1'b1, "R12 invalid slot");
        put(32'h4000_0000, 32'h0777_7000, 1, 1, 0, 2'b11, 0, 8'd9);
        look(32'h3000_0000, 0, 1'b1, "R12 advance");

        pts[0]  = 32'h0040_0123; pts[1]  = 32'h0041_0ABC; pts[2]  = 32'h0040_1000;
        pts[3]  = 32'h1000_03FC; pts[4]  = 32'h1000_0400; pts[5]  = 32'h2000_FFF8;
        pts[6]  = 32'h2001_0000; pts[7]  = 32'hC01F_FFFC; pts[8]  = 32'hC000_0000;
        pts[9]  = 32'h3000_0010; pts[10] = 32'h4000_0888; pts[11] = 32'h0000_0000;

        // Page sizes, tag gating, protection, multi-hit (R4, R5, R6, R8, R9).
        for (int ai = 0; ai < 3; ai++) begin
            cur_asid = (ai == 0) ? 8'd5 : (ai == 1) ? 8'd7 : 8'd9;
            for (int s = 0; s < 2; s++) begin
                sv_mode = s[0];
                for (int j = 0; j < 12; j++)
                    for (int p = 0; p < 2; p++)
                        for (int k = 0; k < 3; k++)
                            look(pts[j], k, p[0], "R5/R12 table sweep");
            end
        end
        idle_chk();

        // Replacement index wrap (R10).
        sv_mode = 1'b0; cur_asid = 8'd5; repl_bound = 6'd3;
        for (int i = 0; i < 10; i++) look(32'h0041_0000, 0, 1'b1, "R10 bound 3");
        repl_bound = 6'd0;
        for (int i = 0; i < 70; i++) look(32'h0041_0000, 1, 1'b1, "R10 full wrap");
        look(32'hA000_0040, 0, 1'b1, "R10 no step on bypass");
        idle_chk();

        summary();
        $finish;
    end
endmodule